// File: doc/BRIEF.md
# Interrupt Pin Edge Detector and Message Builder

This block watches a bank of interrupt input pins and turns each low-to-high transition into one delivery message. Every pin owns a routing entry (mask, destination, vector, delivery mode, destination mode, polarity and trigger mode). These entries come in as plain input vectors from a separate register block. A vector supplied by an external legacy interrupt controller is also an input. It replaces the entry's own vector when the entry selects the external-interrupt delivery mode.

Events from unmasked pins are latched per pin until a message for them leaves on a single valid/ready output channel. When several pins are pending, the lowest-numbered pin goes first. The message fields are formed from the pin's current entry while the message is offered. Destination resolution and message transport sit downstream and are not part of this block.

Top module: `irqmsg_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `msg_valid_o` is low. The remembered level of every pin resets to low.
- R2: A pin whose input changes from low to high, with its mask bit low in that cycle, produces exactly one message. Holding the pin high afterwards produces no further message.
- R3: A pin going from high to low produces no message.
- R4: The mask bit is sampled in the cycle the rising edge is seen. A masked edge is discarded for good, so clearing the mask later produces no message.
- R5: When the entry's delivery mode equals 3'b111 (external interrupt), `msg_vector_o` equals `ext_vector_i`. For any other mode it equals the entry's vector field.
- R6: The message carries the entry's destination, delivery mode and destination-mode bit unchanged. `msg_level_o` carries the entry's polarity bit and `msg_trigger_o` carries its trigger-mode bit.
- R7: Pending pins are served lowest pin number first, one message per cycle in which `msg_valid_o` and `msg_ready_i` are both high.
- R8: A pending event stays offered (`msg_valid_o` held high) until accepted, even if its pin falls in the meantime.
- R9: Further rising edges on a pin whose event is already pending merge into that event and yield one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | N_PINS | Interrupt pin levels |
| ent_mask_i | input | N_PINS | Per-pin mask bit |
| ent_dest_i | input | N_PINS*8 | Per-pin destination, pin i at bits [8i+7:8i] |
| ent_vector_i | input | N_PINS*8 | Per-pin vector, pin i at bits [8i+7:8i] |
| ent_dmode_i | input | N_PINS*3 | Per-pin delivery mode, pin i at bits [3i+2:3i] |
| ent_destmode_i | input | N_PINS | Per-pin destination mode (1 = logical) |
| ent_polarity_i | input | N_PINS | Per-pin polarity bit |
| ent_trigger_i | input | N_PINS | Per-pin trigger mode bit |
| ext_vector_i | input | 8 | Vector from the external legacy controller |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Downstream accepts the message |
| msg_dest_o | output | 8 | Message destination |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_destmode_o | output | 1 | Message destination mode |
| msg_level_o | output | 1 | Message level bit |
| msg_trigger_o | output | 1 | Message trigger bit |

## Verification
The assertions assume that the entry fields and the external vector stay constant while a message is being offered. They also assume that `msg_ready_i` changes only between clock edges. The stimulus reprograms entries and the external vector only after the expected-message queue has drained and the output is idle. Pins and ready are driven just after a rising edge, so every edge, fall and mask change lands in a well-defined cycle.

// File: rtl/irqmsg_pkg.sv
package irqmsg_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int DM_W   = 3;

    localparam logic [DM_W-1:0] DM_EXTINT = 3'b111;

    typedef struct packed {
        logic              masked;
        logic [DEST_W-1:0] dest;
        logic [VEC_W-1:0]  vector;
        logic [DM_W-1:0]   dmode;
        logic              dest_logical;
        logic              polarity;
        logic              trig_level;
    } route_ent_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [VEC_W-1:0]  vector;
        logic [DM_W-1:0]   dmode;
        logic              dest_logical;
        logic              level;
        logic              trigger;
    } irq_msg_t;

    function automatic irq_msg_t form_msg(route_ent_t e, logic [VEC_W-1:0] ext_vec);
        irq_msg_t m;
        m.dest         = e.dest;
        m.vector       = (e.dmode == DM_EXTINT) ? ext_vec : e.vector;
        m.dmode        = e.dmode;
        m.dest_logical = e.dest_logical;
        m.level        = e.polarity;
        m.trigger      = e.trig_level;
        return m;
    endfunction

endpackage

// File: rtl/irqmsg_edge_latch.sv
module irqmsg_edge_latch #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pins_i,
    input  logic [N_PINS-1:0] mask_i,
    input  logic [N_PINS-1:0] clr_i,
    output logic [N_PINS-1:0] pend_o
);
    logic [N_PINS-1:0] pin_q;
    logic [N_PINS-1:0] pend_q;
    logic [N_PINS-1:0] rise;

    // rising edge against the remembered level; falls only refresh pin_q
    assign rise = pins_i & ~pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= '0;
            pend_q <= '0;
        end else begin
            pin_q  <= pins_i;
            // a fresh edge wins over a same-cycle clear of that pin
            pend_q <= (pend_q & ~clr_i) | (rise & ~mask_i);
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irqmsg_pick.sv
module irqmsg_pick #(
    parameter int N_PINS = 8,
    parameter int IDX_W  = 3
) (
    input  logic [N_PINS-1:0] pend_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [N_PINS-1:0] grant_o
);
    // isolate the lowest set bit
    assign grant_o = pend_i & (~pend_i + N_PINS'(1));
    assign any_o   = |pend_i;

    always_comb begin
        idx_o = '0;
        for (int i = N_PINS - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqmsg_form.sv
module irqmsg_form
    import irqmsg_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int IDX_W  = 3
) (
    input  route_ent_t       ent_i [N_PINS],
    input  logic [IDX_W-1:0] idx_i,
    input  logic [VEC_W-1:0] ext_vec_i,
    output irq_msg_t         msg_o
);
    route_ent_t sel;

    always_comb begin
        sel = ent_i[0];
        for (int i = 1; i < N_PINS; i++) begin
            if (idx_i == IDX_W'(i)) sel = ent_i[i];
        end
        msg_o = form_msg(sel, ext_vec_i);
    end
endmodule

// File: rtl/irqmsg_gen.sv
module irqmsg_gen
    import irqmsg_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_PINS-1:0]        pins_i,
    input  logic [N_PINS-1:0]        ent_mask_i,
    input  logic [N_PINS*DEST_W-1:0] ent_dest_i,
    input  logic [N_PINS*VEC_W-1:0]  ent_vector_i,
    input  logic [N_PINS*DM_W-1:0]   ent_dmode_i,
    input  logic [N_PINS-1:0]        ent_destmode_i,
    input  logic [N_PINS-1:0]        ent_polarity_i,
    input  logic [N_PINS-1:0]        ent_trigger_i,
    input  logic [VEC_W-1:0]         ext_vector_i,
    output logic                     msg_valid_o,
    input  logic                     msg_ready_i,
    output logic [DEST_W-1:0]        msg_dest_o,
    output logic [VEC_W-1:0]         msg_vector_o,
    output logic [DM_W-1:0]          msg_dmode_o,
    output logic                     msg_destmode_o,
    output logic                     msg_level_o,
    output logic                     msg_trigger_o
);
    localparam int IDX_W = (N_PINS > 1) ? $clog2(N_PINS) : 1;

    route_ent_t        ent [N_PINS];
    logic [N_PINS-1:0] pend;
    logic [N_PINS-1:0] grant;
    logic [N_PINS-1:0] clr;
    logic [IDX_W-1:0]  idx;
    logic              any;
    irq_msg_t          msg;

    for (genvar g = 0; g < N_PINS; g++) begin : g_ent
        assign ent[g].masked       = ent_mask_i[g];
        assign ent[g].dest         = ent_dest_i[g*DEST_W +: DEST_W];
        assign ent[g].vector       = ent_vector_i[g*VEC_W +: VEC_W];
        assign ent[g].dmode        = ent_dmode_i[g*DM_W +: DM_W];
        assign ent[g].dest_logical = ent_destmode_i[g];
        assign ent[g].polarity     = ent_polarity_i[g];
        assign ent[g].trig_level   = ent_trigger_i[g];
    end

    irqmsg_edge_latch #(.N_PINS(N_PINS)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_i),
        .mask_i (ent_mask_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irqmsg_pick #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_pick (
        .pend_i  (pend),
        .any_o   (any),
        .idx_o   (idx),
        .grant_o (grant)
    );

    irqmsg_form #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_form (
        .ent_i     (ent),
        .idx_i     (idx),
        .ext_vec_i (ext_vector_i),
        .msg_o     (msg)
    );

    assign clr = grant & {N_PINS{any & msg_ready_i}};

    assign msg_valid_o    = any;
    assign msg_dest_o     = msg.dest;
    assign msg_vector_o   = msg.vector;
    assign msg_dmode_o    = msg.dmode;
    assign msg_destmode_o = msg.dest_logical;
    assign msg_level_o    = msg.level;
    assign msg_trigger_o  = msg.trigger;
endmodule

// File: rtl/irqmsg_chk.sv
module irqmsg_chk
    import irqmsg_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [N_PINS-1:0] pins_i,
    input logic [N_PINS-1:0] ent_mask_i,
    input logic [VEC_W-1:0]  ext_vector_i,
    input logic              msg_valid_o,
    input logic              msg_ready_i,
    input logic [VEC_W-1:0]  msg_vector_o,
    input logic [DM_W-1:0]   msg_dmode_o
);
    logic [N_PINS-1:0] ck_prev;

    always_ff @(posedge clk) begin
        if (rst) ck_prev <= '0;
        else     ck_prev <= pins_i;
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !msg_valid_o);

    assert_new_msg_needs_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid_o) |-> $past(|(pins_i & ~ck_prev & ~ent_mask_i)));

    assert_ext_vector_R5: assert property (@(posedge clk) disable iff (rst)
        (msg_valid_o && msg_dmode_o == DM_EXTINT) |-> msg_vector_o == ext_vector_i);

    assert_hold_until_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid_o && !msg_ready_i) |=> msg_valid_o);
endmodule

bind irqmsg_gen irqmsg_chk #(.N_PINS(N_PINS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pins_i       (pins_i),
    .ent_mask_i   (ent_mask_i),
    .ext_vector_i (ext_vector_i),
    .msg_valid_o  (msg_valid_o),
    .msg_ready_i  (msg_ready_i),
    .msg_vector_o (msg_vector_o),
    .msg_dmode_o  (msg_dmode_o)
);

// File: tb/sim_irqmsg_gen.sv
module sim_irqmsg_gen;
    import irqmsg_pkg::*;

    localparam int N = 8;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] pins = '0;
    logic [N-1:0] e_mask = '0;
    logic [DEST_W-1:0] e_dest [N];
    logic [VEC_W-1:0]  e_vec  [N];
    logic [DM_W-1:0]   e_dm   [N];
    logic [N-1:0] e_dl = '0, e_pol = '0, e_trg = '0;
    logic [VEC_W-1:0] ext_vec = 8'h00;
    logic ready = 1'b0;

    logic [N*DEST_W-1:0] dest_flat;
    logic [N*VEC_W-1:0]  vec_flat;
    logic [N*DM_W-1:0]   dm_flat;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            dest_flat[i*DEST_W +: DEST_W] = e_dest[i];
            vec_flat[i*VEC_W +: VEC_W]    = e_vec[i];
            dm_flat[i*DM_W +: DM_W]       = e_dm[i];
        end
    end

    logic valid, destmode, level, trigger;
    logic [DEST_W-1:0] dest;
    logic [VEC_W-1:0]  vector;
    logic [DM_W-1:0]   dmode;

    irqmsg_gen #(.N_PINS(N)) u0 (
        .clk(clk), .rst(rst), .pins_i(pins), .ent_mask_i(e_mask),
        .ent_dest_i(dest_flat), .ent_vector_i(vec_flat), .ent_dmode_i(dm_flat),
        .ent_destmode_i(e_dl), .ent_polarity_i(e_pol), .ent_trigger_i(e_trg),
        .ext_vector_i(ext_vec), .msg_valid_o(valid), .msg_ready_i(ready),
        .msg_dest_o(dest), .msg_vector_o(vector), .msg_dmode_o(dmode),
        .msg_destmode_o(destmode), .msg_level_o(level), .msg_trigger_o(trigger)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    irq_msg_t exp_q [$];

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic irq_msg_t expect_of(int i);
        irq_msg_t m;
        m.dest         = e_dest[i];
        m.vector       = (e_dm[i] == 3'b111) ? ext_vec : e_vec[i];
        m.dmode        = e_dm[i];
        m.dest_logical = e_dl[i];
        m.level        = e_pol[i];
        m.trigger      = e_trg[i];
        return m;
    endfunction

    task automatic push_exp(int i);
        exp_q.push_back(expect_of(i));
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // monitor: handshake seen at the falling edge completes at the next rising edge
    always @(negedge clk) begin
        if (!rst && valid && ready) begin
            irq_msg_t got;
            got = '{dest: dest, vector: vector, dmode: dmode,
                    dest_logical: destmode, level: level, trigger: trigger};
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected message", 64'(got), 64'h0);
            end else begin
                irq_msg_t e;
                e = exp_q.pop_front();
                check(got == e, "R6", "message fields/order", 64'(got), 64'(e));
            end
        end
    end

    task automatic drain(string req);
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin
            tick(1);
            guard++;
        end
        check(exp_q.size() == 0, req, "messages still expected", 64'(exp_q.size()), 64'h0);
        tick(2);
        @(negedge clk);
        check(!valid, req, "valid after drain", 64'(valid), 64'h0);
        tick(1);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            e_dest[i] = 8'h10 + 8'(i);
            e_vec[i]  = 8'h40 + 8'(i * 3);
            e_dm[i]   = 3'(i % 5);
        end
        e_dl  = 8'b1010_0110;
        e_pol = 8'b0110_1001;
        e_trg = 8'b1100_0011;
        ext_vec = 8'hA5;

        // R1: reset state
        tick(3);
        @(negedge clk);
        check(!valid, "R1", "valid in reset", 64'(valid), 64'h0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(!valid, "R1", "valid after reset", 64'(valid), 64'h0);
        tick(1);

        // R2 and R6: one message from a rising pin held high
        ready = 1'b1;
        pins[1] = 1'b1;
        push_exp(1);
        tick(12);
        drain("R2");

        // R3: falling pin gives nothing
        pins[1] = 1'b0;
        tick(4);
        @(negedge clk);
        check(!valid, "R3", "valid after fall", 64'(valid), 64'h0);
        tick(1);

        // R5: external vector used for mode 3'b111, entry vector for 3'b110
        ready = 1'b0;
        e_dm[4] = 3'b111;
        e_dm[2] = 3'b110;
        tick(1);
        pins[4] = 1'b1;
        push_exp(4);
        tick(2);
        @(negedge clk);
        check(vector == 8'hA5, "R5", "external vector", 64'(vector), 64'hA5);
        tick(1);
        ready = 1'b1;
        drain("R5");
        ready = 1'b0;
        pins[2] = 1'b1;
        push_exp(2);
        tick(2);
        @(negedge clk);
        check(vector == e_vec[2], "R5", "entry vector", 64'(vector), 64'(e_vec[2]));
        tick(1);
        ready = 1'b1;
        drain("R5");
        pins = '0;
        tick(2);

        // R4: masked edge dropped, later unmask does not revive it
        e_mask[6] = 1'b1;
        tick(1);
        pins[6] = 1'b1;
        tick(3);
        @(negedge clk);
        check(!valid, "R4", "valid on masked edge", 64'(valid), 64'h0);
        tick(1);
        e_mask[6] = 1'b0;
        tick(3);
        @(negedge clk);
        check(!valid, "R4", "valid after unmask", 64'(valid), 64'h0);
        tick(1);
        pins[6] = 1'b0;
        tick(2);

        // R7: simultaneous edges served lowest pin first
        ready = 1'b0;
        pins[7] = 1'b1; pins[5] = 1'b1; pins[2] = 1'b1;
        push_exp(2); push_exp(5); push_exp(7);
        tick(3);
        @(negedge clk);
        check(valid, "R7", "valid while stalled", 64'(valid), 64'h1);
        check(dest == e_dest[2], "R7", "lowest pin offered", 64'(dest), 64'(e_dest[2]));
        tick(1);
        ready = 1'b1;
        drain("R7");
        pins = '0;
        tick(2);

        // R8: pending survives the pin falling before acceptance
        ready = 1'b0;
        pins[3] = 1'b1;
        push_exp(3);
        tick(1);
        pins[3] = 1'b0;
        tick(5);
        @(negedge clk);
        check(valid, "R8", "valid after pin fell", 64'(valid), 64'h1);
        tick(1);
        ready = 1'b1;
        drain("R8");

        // R9: repeated edges while pending merge into one message
        ready = 1'b0;
        pins[0] = 1'b1;
        push_exp(0);
        tick(1); pins[0] = 1'b0;
        tick(1); pins[0] = 1'b1;
        tick(1); pins[0] = 1'b0;
        tick(2);
        ready = 1'b1;
        drain("R9");

        finish_run();
    end
endmodule